// File: doc/BRIEF.md
# USB Device Address Filter

This block holds the USB function address that firmware assigns during enumeration and decides, for every token packet the packet decoder reports, whether the token targets this device. Firmware reads and writes one 8-bit register over a simple CPU register bus. The top bit of that register arms the filter and the low seven bits hold the address. Until firmware sets the arming bit, the block ignores all traffic, including traffic to address 0.

When a valid token carries the stored address and names endpoint 0, 1 or 2, the block raises a hit flag and a one-hot endpoint select one clock later. Endpoint 0 is the bidirectional control endpoint, and each endpoint has its own 8-byte data buffer elsewhere in the controller. A token that reaches the armed address but names an endpoint this device does not implement raises a no-response flag instead. A USB bus reset clears the register in the same way a system reset does, so the device goes back to the unarmed state with address 0.

Top module: `usb_dev_addr_filter`

## Requirements
- R1: After a system reset (rst_n low at a clock edge), the address register reads 8'h00, and hit, ep_sel and no_resp are 0.
- R2: A write with cpu_sel=1 and cpu_we=1 at cpu_addr 8'h10 loads cpu_wdata into the register. Bit 7 is the enable bit and bits 6:0 are the device address. A read with cpu_sel=1 at 8'h10 returns the register on cpu_rdata in the same cycle. Writes to any other offset leave the register unchanged, and reads at any other offset, or with cpu_sel=0, return 8'h00.
- R3: While the enable bit is 0, hit, ep_sel and no_resp stay 0 for every token, including a token whose address equals bits 6:0.
- R4: A token with tok_valid=1, enable bit 1, tok_addr equal to bits 6:0 and tok_ep from 0 to 2 sets hit for exactly the one cycle after the edge that samples it. The address held before that edge is the one compared.
- R5: ep_sel is one-hot with bit n set for endpoint n whenever hit is 1, and it is 3'b000 whenever hit is 0.
- R6: A token that matches the enabled address but has tok_ep of 3 or more sets no_resp for one cycle, with hit=0 and ep_sel=3'b000.
- R7: A bus_reset pulse clears the register to 8'h00, which leaves it unarmed with address 0.
- R8: When bus_reset and a register write occur in the same cycle, the register ends at 8'h00.
- R9: A token sampled in the same cycle as bus_reset produces neither hit nor no_resp.
- R10: A valid token whose address differs from bits 6:0 produces neither hit nor no_resp.
- R11: When tok_valid is 0, hit and no_resp are 0 in the following cycle, whatever tok_addr and tok_ep hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cpu_sel | input | 1 | Register bus access strobe |
| cpu_we | input | 1 | Write qualifier for cpu_sel |
| cpu_addr | input | 8 | Register bus offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the register |
| bus_reset | input | 1 | USB bus reset pulse from the line monitor |
| tok_valid | input | 1 | Decoded token present this cycle |
| tok_addr | input | 7 | Token function address |
| tok_ep | input | 4 | Token endpoint number |
| hit | output | 1 | Token is for this device and a supported endpoint |
| ep_sel | output | 3 | One-hot endpoint select |
| no_resp | output | 1 | Token is for this device but names an unsupported endpoint |

## Verification
The token results (hit, ep_sel, no_resp) are registered, so they are due on the edge that follows the cycle in which tok_valid is sampled. The register content changes on the edge that samples a write or a bus reset. cpu_rdata follows the register within the same cycle. The bench drives stimulus on the falling edge, updates its reference model on the rising edge from the inputs held across that edge, and compares all outputs one time unit later. In this way a registered result is always checked against the cycle that produced it, and read data is checked against the register value after that edge.

// File: rtl/usb_af_pkg.sv
// Package: shared widths for the USB device address filter.
// Assumes an 8-bit register bus, which holds one enable bit above a 7-bit address.
package usb_af_pkg;
    localparam int DEV_ADDR_W = 7;
    localparam int EP_NUM_W   = 4;
    localparam int EP_COUNT   = 3;
    localparam int BUS_AW     = 8;
    localparam logic [BUS_AW-1:0] ADDR_REG_OFS = 8'h10;
endpackage

// File: rtl/usb_af_addr_reg.sv
// Module: usb_af_addr_reg
// Holds the device address register: {enable, address}.
// Assumes a single-cycle register bus. A bus reset beats a firmware write in the same cycle.
module usb_af_addr_reg #(
    parameter int                ADDR_W = usb_af_pkg::DEV_ADDR_W,
    parameter int                BUS_AW = usb_af_pkg::BUS_AW,
    parameter logic [BUS_AW-1:0] REG_OFS = usb_af_pkg::ADDR_REG_OFS,
    localparam int               DW     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [BUS_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic              bus_reset,
    output logic [DW-1:0]     cpu_rdata,
    output logic              reg_en,
    output logic [ADDR_W-1:0] reg_addr
);
    logic          hit_ofs;
    logic [DW-1:0] reg_q;

    // Decode the register offset for both reads and writes.
    assign hit_ofs = cpu_sel && (cpu_addr == REG_OFS);

    // Register update: the resets come first, then the firmware write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (bus_reset) begin
            reg_q <= '0;
        end else if (hit_ofs && cpu_we) begin
            reg_q <= cpu_wdata;
        end
    end

    // Read mux: returns the register at its offset and zero elsewhere.
    always_comb begin
        cpu_rdata = hit_ofs ? reg_q : '0;
    end

    // Split the register into its fields for the comparator.
    assign reg_en   = reg_q[DW-1];
    assign reg_addr = reg_q[ADDR_W-1:0];
endmodule

// File: rtl/usb_af_ep_decode.sv
// Module: usb_af_ep_decode
// Turns an endpoint number into a one-hot select over the implemented endpoints.
// Assumes NUM_EP fits in an EPN_W-bit number. in_range is low for any number outside the set.
module usb_af_ep_decode #(
    parameter int EPN_W  = usb_af_pkg::EP_NUM_W,
    parameter int NUM_EP = usb_af_pkg::EP_COUNT
) (
    input  logic [EPN_W-1:0]  ep_num,
    output logic [NUM_EP-1:0] sel,
    output logic              in_range
);
    // One comparator for each implemented endpoint.
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        assign sel[i] = (ep_num == EPN_W'(i));
    end

    // The number is supported when any comparator fires.
    assign in_range = |sel;
endmodule

// File: rtl/usb_af_tok_match.sv
// Module: usb_af_tok_match
// Compares a decoded token against the stored address and registers the verdict.
// Assumes tok_* are valid only while tok_valid is high. A token sampled together
// with a bus reset is dropped, because the address it targeted is being cleared.
module usb_af_tok_match #(
    parameter int ADDR_W = usb_af_pkg::DEV_ADDR_W,
    parameter int EPN_W  = usb_af_pkg::EP_NUM_W,
    parameter int NUM_EP = usb_af_pkg::EP_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EPN_W-1:0]  tok_ep,
    input  logic              bus_reset,
    input  logic              reg_en,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              hit,
    output logic [NUM_EP-1:0] ep_sel,
    output logic              no_resp
);
    logic              for_us;
    logic [NUM_EP-1:0] dec_sel;
    logic              dec_ok;

    // Endpoint decoder for the token's endpoint field.
    usb_af_ep_decode #(
        .EPN_W  (EPN_W),
        .NUM_EP (NUM_EP)
    ) u_dec (
        .ep_num   (tok_ep),
        .sel      (dec_sel),
        .in_range (dec_ok)
    );

    // Address qualification: armed, equal address, valid token, no reset under way.
    assign for_us = tok_valid && reg_en && !bus_reset && (tok_addr == reg_addr);

    // Verdict register: one cycle of hit/select or no-response for each token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            ep_sel  <= '0;
            no_resp <= 1'b0;
        end else begin
            hit     <= for_us && dec_ok;
            ep_sel  <= for_us ? dec_sel : '0;
            no_resp <= for_us && !dec_ok;
        end
    end
endmodule

// File: rtl/usb_dev_addr_filter.sv
// Module: usb_dev_addr_filter (top)
// Device address register plus token filter. Firmware owns the register, the
// packet decoder supplies tokens, and the endpoint logic consumes ep_sel.
// Assumes every input is synchronous to clk.
module usb_dev_addr_filter #(
    parameter int                ADDR_W  = usb_af_pkg::DEV_ADDR_W,
    parameter int                EPN_W   = usb_af_pkg::EP_NUM_W,
    parameter int                NUM_EP  = usb_af_pkg::EP_COUNT,
    parameter int                BUS_AW  = usb_af_pkg::BUS_AW,
    parameter logic [BUS_AW-1:0] REG_OFS = usb_af_pkg::ADDR_REG_OFS,
    localparam int               DW      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [BUS_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    input  logic              bus_reset,
    input  logic              tok_valid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EPN_W-1:0]  tok_ep,
    output logic              hit,
    output logic [NUM_EP-1:0] ep_sel,
    output logic              no_resp
);
    logic              reg_en;
    logic [ADDR_W-1:0] reg_addr;

    // Firmware-visible address register.
    usb_af_addr_reg #(
        .ADDR_W  (ADDR_W),
        .BUS_AW  (BUS_AW),
        .REG_OFS (REG_OFS)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .bus_reset (bus_reset),
        .cpu_rdata (cpu_rdata),
        .reg_en    (reg_en),
        .reg_addr  (reg_addr)
    );

    // Token comparator and verdict register.
    usb_af_tok_match #(
        .ADDR_W (ADDR_W),
        .EPN_W  (EPN_W),
        .NUM_EP (NUM_EP)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_addr  (tok_addr),
        .tok_ep    (tok_ep),
        .bus_reset (bus_reset),
        .reg_en    (reg_en),
        .reg_addr  (reg_addr),
        .hit       (hit),
        .ep_sel    (ep_sel),
        .no_resp   (no_resp)
    );
endmodule

// File: rtl/usb_dev_addr_filter_chk.sv
// Module: usb_dev_addr_filter_chk
// Assertion checker bound into usb_dev_addr_filter. It observes ports and the
// register fields that the comparator reads.
module usb_dev_addr_filter_chk #(
    parameter int ADDR_W = 7,
    parameter int EPN_W  = 4,
    parameter int NUM_EP = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_reset,
    input logic              tok_valid,
    input logic [ADDR_W-1:0] tok_addr,
    input logic [EPN_W-1:0]  tok_ep,
    input logic              reg_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              hit,
    input logic [NUM_EP-1:0] ep_sel,
    input logic              no_resp
);
    // Select is never more than one-hot.
    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ep_sel));

    // Select is active exactly when hit is.
    assert_sel_tracks_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_sel != '0) == hit);

    // No-response excludes hit and select.
    assert_noresp_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        no_resp |-> (!hit && ep_sel == '0));

    // An unarmed register yields nothing on the next cycle.
    assert_unarmed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |=> (!hit && !no_resp));

    // A bus reset empties the register.
    assert_busrst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!reg_en && reg_addr == '0));

    // A qualifying token produces hit on the next cycle.
    assert_token_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && reg_en && !bus_reset && tok_addr == reg_addr
         && tok_ep < EPN_W'(NUM_EP)) |=> hit);

    // Without a token there is no verdict.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> (!hit && !no_resp));

    // A token during a bus reset is dropped.
    assert_rst_token_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!hit && !no_resp));
endmodule

bind usb_dev_addr_filter usb_dev_addr_filter_chk #(
    .ADDR_W (ADDR_W),
    .EPN_W  (EPN_W),
    .NUM_EP (NUM_EP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .tok_valid (tok_valid),
    .tok_addr  (tok_addr),
    .tok_ep    (tok_ep),
    .reg_en    (reg_en),
    .reg_addr  (reg_addr),
    .hit       (hit),
    .ep_sel    (ep_sel),
    .no_resp   (no_resp)
);

// File: tb/usb_dev_addr_filter_test.sv
// Bench for usb_dev_addr_filter: a behavioural model is updated on each rising
// edge, and the outputs are compared 1 ns later.
`timescale 1ns/1ps
module usb_dev_addr_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       bus_reset = 1'b0, tok_valid = 1'b0;
    logic [6:0] tok_addr = '0;
    logic [3:0] tok_ep = '0;
    logic       hit, no_resp;
    logic [2:0] ep_sel;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string req = "R1";

    // Model state
    logic [7:0] m_reg = '0;
    logic       e_hit = 1'b0, e_nr = 1'b0;
    logic [2:0] e_sel = '0;
    logic [7:0] e_rd;

    always #5 clk = ~clk;

    usb_dev_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .bus_reset(bus_reset), .tok_valid(tok_valid), .tok_addr(tok_addr),
        .tok_ep(tok_ep), .hit(hit), .ep_sel(ep_sel), .no_resp(no_resp)
    );

    // Reference model and comparison on every rising edge
    always @(posedge clk) begin
        bit ours;
        ours = tok_valid && !bus_reset && m_reg[7] && (tok_addr == m_reg[6:0]);
        if (!rst_n) begin
            m_reg = '0; e_hit = 0; e_sel = '0; e_nr = 0;
        end else begin
            e_hit = ours && (int'(tok_ep) < 3);
            e_sel = e_hit ? (3'b001 << tok_ep) : 3'b000;
            e_nr  = ours && (int'(tok_ep) >= 3);
            if (bus_reset) m_reg = '0;
            else if (cpu_sel && cpu_we && cpu_addr == 8'h10) m_reg = cpu_wdata;
        end
        #1;
        e_rd = (cpu_sel && cpu_addr == 8'h10) ? m_reg : 8'h00;
        vectors++;
        if (hit !== e_hit || ep_sel !== e_sel || no_resp !== e_nr || cpu_rdata !== e_rd) begin
            miscompares++;
            $display("FAIL %s t=%0t: hit=%b ep_sel=%b no_resp=%b rdata=%h expected hit=%b ep_sel=%b no_resp=%b rdata=%h",
                     req, $time, hit, ep_sel, no_resp, cpu_rdata, e_hit, e_sel, e_nr, e_rd);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            miscompares++;
            $display("FAIL watchdog: cycles=%0d expected <= 5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic drive(input logic s, input logic w, input logic [7:0] a,
                         input logic [7:0] d, input logic br, input logic tv,
                         input logic [6:0] ta, input logic [3:0] te, input string r);
        @(negedge clk);
        cpu_sel = s; cpu_we = w; cpu_addr = a; cpu_wdata = d;
        bus_reset = br; tok_valid = tv; tok_addr = ta; tok_ep = te; req = r;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string r);
        drive(1, 1, a, d, 0, 0, '0, '0, r);
    endtask

    task automatic rd(input logic [7:0] a, input string r);
        drive(1, 0, a, 8'hFF, 0, 0, '0, '0, r);
    endtask

    task automatic tok(input logic [6:0] ta, input logic [3:0] te, input string r);
        drive(0, 0, 8'h00, 8'h00, 0, 1, ta, te, r);
    endtask

    task automatic idle(input string r);
        drive(0, 0, 8'h00, 8'h00, 0, 0, '0, '0, r);
    endtask

    initial begin
        req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h10, "R1");                    // reads zero after reset
        tok(7'd0, 4'd0, "R3");              // address 0, unarmed
        wr(8'h10, 8'h05, "R2");             // address 5, unarmed
        rd(8'h10, "R2");
        tok(7'd5, 4'd0, "R3");              // equal address but unarmed
        tok(7'd5, 4'd1, "R3");
        wr(8'h11, 8'h85, "R2");             // wrong offset is ignored
        rd(8'h10, "R2");
        rd(8'h11, "R2");
        drive(0, 0, 8'h10, 8'h00, 0, 0, '0, '0, "R2");  // no select: read zero
        wr(8'h10, 8'h85, "R2");             // arm, address 5
        rd(8'h10, "R2");
        tok(7'd5, 4'd0, "R4");
        idle("R4");
        tok(7'd5, 4'd1, "R5");
        tok(7'd5, 4'd2, "R5");              // back-to-back tokens
        tok(7'd5, 4'd3, "R6");
        tok(7'd5, 4'd15, "R6");
        tok(7'd6, 4'd0, "R10");
        tok(7'd4, 4'd2, "R10");
        drive(0, 0, 8'h00, 8'h00, 0, 0, 7'd5, 4'd1, "R11");  // fields set, no strobe
        idle("R11");
        wr(8'h10, 8'hFF, "R2");             // top address 0x7F
        tok(7'h7F, 4'd2, "R5");
        tok(7'h7F, 4'd7, "R6");
        drive(1, 0, 8'h10, 8'h00, 1, 0, '0, '0, "R7");  // bus reset
        rd(8'h10, "R7");
        tok(7'h7F, 4'd0, "R7");
        tok(7'd0, 4'd0, "R7");              // address 0 after reset is not armed
        wr(8'h10, 8'h85, "R2");
        drive(1, 1, 8'h10, 8'h9A, 1, 0, '0, '0, "R8");  // reset beats write
        rd(8'h10, "R8");
        wr(8'h10, 8'h85, "R2");
        drive(0, 0, 8'h00, 8'h00, 1, 1, 7'd5, 4'd1, "R9");  // token during reset
        idle("R9");
        rd(8'h10, "R9");
        wr(8'h10, 8'h85, "R2");
        tok(7'd5, 4'd2, "R4");
        drive(0, 0, 8'h00, 8'h00, 0, 0, '0, '0, "R1");
        rst_n = 1'b0;                       // system reset mid-run
        idle("R1");
        rst_n = 1'b1;
        rd(8'h10, "R1");
        tok(7'd5, 4'd2, "R3");
        idle("R3");
        idle("R3");
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule